// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block turns activity on one dedicated interrupt input and on twelve general-purpose pins into three interrupt request lines for a CPU. The dedicated input can be set to one of four sense modes: low level, any change, falling edge or rising edge. The general pins form two pin-change groups. Group 0 has eight pins and group 1 has four. Each pin has its own mask bit and each group has an enable bit. Any change on an unmasked pin of an enabled group raises that group's request.

All pin inputs are read from the pad, whatever the pin's direction. So a pin that the chip drives as an output still raises interrupts. Every input goes through a two-flop synchronizer. Edge events and pin-change events set sticky pending flags. The CPU clears a flag either with an acknowledge pulse or by writing 1 to the flag through a small register port. A request reaches the CPU only when the global interrupt enable is also high.

Top module: `ext_pcint_ctrl`

Register map on `reg_addr_i`:

| Address | Contents |
|---------|----------|
| 0 | Enable register |
| 1 | Sense code, bits 1:0 |
| 2 | Group-0 mask, 8 bits |
| 3 | Group-1 mask, bits 3:0 |
| 4 | Pending flags: bit 0 dedicated input, bit 1 group 0, bit 2 group 1 |

## Requirements
- R1: After reset, every register is 0, all flags read 0 and all three request outputs are low.
- R2: In the enable register (address 0), bit 0 enables the dedicated input, bit 4 enables group 0 and bit 5 enables group 1. Bits 7:6 and 3:1 always read 0, so writing 8'hFF reads back 8'h31.
- R3: Sense code 00 (address 1) raises `ext_irq_o` while the synchronized dedicated input is low. It sets no flag and the request drops once the input returns high.
- R4: Sense code 01 sets flag bit 0 (address 4) on both rising and falling changes of the dedicated input.
- R5: Sense code 10 sets flag bit 0 only on falling changes. Sense code 11 sets it only on rising changes.
- R6: Any change on pin i sets flag bit 1 (for i<8) or flag bit 2 (for i>=8), provided that pin's mask bit is 1 and its group's enable is 1. Mask bit i of group 0 is bit i at address 2. Pin 8+j maps to bit j at address 3. A change on a masked-off pin, or on a pin of a disabled group, sets no flag.
- R7: A change applied before clock edge 1 shows in the flag after clock edge 3 and not after clock edge 2.
- R8: Each request output equals its flag (or, for the dedicated input, its level condition) ANDed with its enable bit and with `gie_i`.
- R9: A flag stays set until `ack_i` bit k is high for one cycle or a 1 is written to flag bit k. Writing 0 leaves the flag unchanged. Index k is 0 for the dedicated input, 1 for group 0 and 2 for group 1.
- R10: When a qualifying event and a clear arrive in the same cycle, the flag stays set.
- R11: Changing the sense code while the input is steady causes no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Global interrupt enable |
| ext_pin_i | input | 1 | Dedicated interrupt pin, pad value |
| pin_i | input | 12 | General pins, pad values; bits 7:0 are group 0, bits 11:8 are group 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| ack_i | input | 3 | Per-source flag clear on acknowledge |
| ext_irq_o | output | 1 | Dedicated-input request |
| grp0_irq_o | output | 1 | Group-0 request |
| grp1_irq_o | output | 1 | Group-1 request |

## Verification
Several kinds of fault show up at the ports, and each shows within a fixed number of cycles:

- **Previous-sample register.** If it stalls or goes wrong, the bench sees a missing flag or a spurious flag on the third clock edge after a pin change, or right after a sense-code change.
- **Enable or mask decode.** If it is crossed, a flag appears on the wrong bit at address 4, or appears where none should.
- **Set-versus-clear priority.** If it is lost, the flag reads 0 in the cycle right after the coincident acknowledge.
- **Gating.** Both flags and requests are combinational views of the registers. A gating error therefore shows in the same cycle that `gie_i` or an enable changes.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int unsigned EN_EXT_BIT  = 0;
  localparam int unsigned EN_GRP0_BIT = 4;
  localparam int unsigned EN_GRP1_BIT = 5;

  localparam int unsigned FLG_EXT  = 0;
  localparam int unsigned FLG_GRP0 = 1;
  localparam int unsigned FLG_GRP1 = 2;
  localparam int unsigned NSRC     = 3;

  localparam logic [2:0] ADDR_EN   = 3'd0;
  localparam logic [2:0] ADDR_SNS  = 3'd1;
  localparam logic [2:0] ADDR_MSK0 = 3'd2;
  localparam logic [2:0] ADDR_MSK1 = 3'd3;
  localparam logic [2:0] ADDR_FLG  = 3'd4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  // Per-bit synchronizer plus previous-sample stage. All stages update every clock.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i]   <= 1'b0;
        s2_q[i]   <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        s1_q[i]   <= pad_i[i];
        s2_q[i]   <= s1_q[i];
        prev_q[i] <= s2_q[i];
      end
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/ext_sense.sv
module ext_sense
  import pcint_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cur_i,
  input  logic   prev_i,
  input  sense_e sense_i,
  input  logic   en_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   level_o
);
  logic evt, flag_q;

  always_comb begin
    unique case (sense_i)
      SNS_ANY:  evt = cur_i ^ prev_i;
      SNS_FALL: evt = prev_i & ~cur_i;
      SNS_RISE: evt = ~prev_i & cur_i;
      default:  evt = 1'b0;
    endcase
  end

  // Set wins over clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_q <= 1'b0;
    else if (en_i && evt)   flag_q <= 1'b1;
    else if (clr_i)         flag_q <= 1'b0;
  end

  assign flag_o  = flag_q;
  assign level_o = (sense_i == SNS_LOW) && !cur_i;

  p_level_no_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SNS_LOW) |=> !$rose(flag_o));

  p_no_set_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(flag_o));
endmodule

// File: rtl/pcint_group.sv
module pcint_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic         hit, flag_q;
  logic [W-1:0] chg;

  assign chg = (cur_i ^ prev_i) & mask_i;
  assign hit = en_i && (|chg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_masked_no_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || mask_i == '0) |=> !$rose(flag_o));

  p_set_beats_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (cur_i != prev_i) && ((cur_i ^ prev_i) & mask_i) != '0 && clr_i) |=> flag_o);
endmodule

// File: rtl/ext_pcint_ctrl.sv
module ext_pcint_ctrl
  import pcint_pkg::*;
#(
  parameter int unsigned N_GRP0 = 8,
  parameter int unsigned N_GRP1 = 4,
  parameter int unsigned AW     = 3,
  parameter int unsigned DW     = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     gie_i,
  input  logic                     ext_pin_i,
  input  logic [N_GRP0+N_GRP1-1:0] pin_i,
  input  logic                     reg_we_i,
  input  logic [AW-1:0]            reg_addr_i,
  input  logic [DW-1:0]            reg_wdata_i,
  output logic [DW-1:0]            reg_rdata_o,
  input  logic [NSRC-1:0]          ack_i,
  output logic                     ext_irq_o,
  output logic                     grp0_irq_o,
  output logic                     grp1_irq_o
);
  localparam int unsigned NPINS = N_GRP0 + N_GRP1;
  localparam int unsigned NSYNC = NPINS + 1;

  logic              en_ext_q, en_g0_q, en_g1_q;
  sense_e            sense_q;
  logic [N_GRP0-1:0] mask0_q;
  logic [N_GRP1-1:0] mask1_q;
  logic [NSYNC-1:0]  cur, prev;
  logic [NSRC-1:0]   flags, clr;
  logic              level_act;

  function automatic logic hit(input logic [AW-1:0] a, input logic [2:0] ref_a);
    return reg_we_i && (a == AW'(ref_a));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_ext_q <= 1'b0;
      en_g0_q  <= 1'b0;
      en_g1_q  <= 1'b0;
      sense_q  <= SNS_LOW;
      mask0_q  <= '0;
      mask1_q  <= '0;
    end else begin
      if (hit(reg_addr_i, ADDR_EN)) begin
        en_ext_q <= reg_wdata_i[EN_EXT_BIT];
        en_g0_q  <= reg_wdata_i[EN_GRP0_BIT];
        en_g1_q  <= reg_wdata_i[EN_GRP1_BIT];
      end
      if (hit(reg_addr_i, ADDR_SNS))  sense_q <= sense_e'(reg_wdata_i[1:0]);
      if (hit(reg_addr_i, ADDR_MSK0)) mask0_q <= reg_wdata_i[N_GRP0-1:0];
      if (hit(reg_addr_i, ADDR_MSK1)) mask1_q <= reg_wdata_i[N_GRP1-1:0];
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_clr
    assign clr[k] = ack_i[k] | (hit(reg_addr_i, ADDR_FLG) & reg_wdata_i[k]);
  end

  pin_sync #(.W(NSYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  ({ext_pin_i, pin_i}),
    .cur_o  (cur),
    .prev_o (prev)
  );

  ext_sense u_ext (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cur_i   (cur[NPINS]),
    .prev_i  (prev[NPINS]),
    .sense_i (sense_q),
    .en_i    (en_ext_q),
    .clr_i   (clr[FLG_EXT]),
    .flag_o  (flags[FLG_EXT]),
    .level_o (level_act)
  );

  pcint_group #(.W(N_GRP0)) u_grp0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur[N_GRP0-1:0]),
    .prev_i (prev[N_GRP0-1:0]),
    .mask_i (mask0_q),
    .en_i   (en_g0_q),
    .clr_i  (clr[FLG_GRP0]),
    .flag_o (flags[FLG_GRP0])
  );

  pcint_group #(.W(N_GRP1)) u_grp1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur[NPINS-1:N_GRP0]),
    .prev_i (prev[NPINS-1:N_GRP0]),
    .mask_i (mask1_q),
    .en_i   (en_g1_q),
    .clr_i  (clr[FLG_GRP1]),
    .flag_o (flags[FLG_GRP1])
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      AW'(ADDR_EN): begin
        reg_rdata_o[EN_EXT_BIT]  = en_ext_q;
        reg_rdata_o[EN_GRP0_BIT] = en_g0_q;
        reg_rdata_o[EN_GRP1_BIT] = en_g1_q;
      end
      AW'(ADDR_SNS):  reg_rdata_o = DW'(sense_q);
      AW'(ADDR_MSK0): reg_rdata_o = DW'(mask0_q);
      AW'(ADDR_MSK1): reg_rdata_o = DW'(mask1_q);
      AW'(ADDR_FLG):  reg_rdata_o = DW'(flags);
      default:        reg_rdata_o = '0;
    endcase
  end

  assign ext_irq_o  = gie_i & en_ext_q & (flags[FLG_EXT] | level_act);
  assign grp0_irq_o = gie_i & en_g0_q & flags[FLG_GRP0];
  assign grp1_irq_o = gie_i & en_g1_q & flags[FLG_GRP1];

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == AW'(ADDR_EN)) |-> (reg_rdata_o & 8'hCE) == '0);

  p_irq_needs_gie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_irq_o || grp0_irq_o || grp1_irq_o) |-> gie_i);
endmodule

// File: tb/test_ext_pcint_ctrl.sv
module test_ext_pcint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gie = 1'b0;
  logic        ext_pin = 1'b1;
  logic [11:0] pins = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  ack = '0;
  logic        ext_irq, g0_irq, g1_irq;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = ~clk;

  ext_pcint_ctrl i_ext_pcint_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .gie_i(gie), .ext_pin_i(ext_pin), .pin_i(pins),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .ext_irq_o(ext_irq), .grp0_irq_o(g0_irq), .grp1_irq_o(g1_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 3'd4;
  endtask

  // Called right after a negedge; does not advance time past the next edge.
  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       start;
    int         expv;
    idle(2);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      peek(3'(a), d);
      chk("R1 reg", d, 0);
    end
    chk("R1 irq", {ext_irq, g0_irq, g1_irq}, 0);

    // R2 layout and reserved bits
    wr(3'd0, 8'hFF);
    peek(3'd0, d); chk("R2 ff", d, 8'h31);
    wr(3'd0, 8'h00);
    peek(3'd0, d); chk("R2 zero", d, 0);
    wr(3'd0, 8'h31);
    gie = 1'b1;

    // R3 low level, not latched
    wr(3'd1, 8'h00);
    ext_pin = 1'b0;
    idle(3);
    chk("R3 level irq", ext_irq, 1);
    peek(3'd4, d); chk("R3 no flag", d[0], 0);
    ext_pin = 1'b1;
    idle(3);
    chk("R3 release", ext_irq, 0);
    wr(3'd4, 8'h07);

    // R4/R5 sweep over edge modes and directions
    for (int s = 1; s < 4; s++) begin
      for (int dir = 0; dir < 2; dir++) begin
        start = (dir == 0);
        wr(3'd1, 8'(s));
        @(negedge clk); ext_pin = start;
        idle(4);
        wr(3'd4, 8'h01);
        @(negedge clk); ext_pin = ~start;
        idle(3);
        expv = (s == 1) || (s == 2 && start == 1'b1) || (s == 3 && start == 1'b0);
        peek(3'd4, d);
        chk(s == 1 ? "R4 any edge" : "R5 directed edge", d[0], expv);
      end
    end
    wr(3'd4, 8'h07);

    // R11 sense change with steady high input
    @(negedge clk); ext_pin = 1'b1;
    wr(3'd1, 8'h02); idle(4); wr(3'd4, 8'h01);
    wr(3'd1, 8'h03); idle(4);
    peek(3'd4, d); chk("R11 no spurious", d[0], 0);
    wr(3'd1, 8'h01); idle(4);
    peek(3'd4, d); chk("R11 no spurious any", d[0], 0);

    // R7 latency on group 0 pin 2
    wr(3'd2, 8'h04);
    @(negedge clk); pins[2] = ~pins[2];
    @(negedge clk); @(negedge clk);
    peek(3'd4, d); chk("R7 not yet", d[1], 0);
    @(negedge clk);
    peek(3'd4, d); chk("R7 set", d[1], 1);
    wr(3'd4, 8'h07);

    // R6 sweep: each pin, masked-in and masked-out
    for (int p = 0; p < 12; p++) begin
      for (int m = 0; m < 2; m++) begin
        logic [11:0] msk;
        msk = (m == 1) ? (12'h001 << p) : ~(12'h001 << p);
        wr(3'd2, msk[7:0]);
        wr(3'd3, {4'h0, msk[11:8]});
        wr(3'd4, 8'h07);
        @(negedge clk); pins[p] = ~pins[p];
        idle(3);
        expv = (m == 1) ? ((p < 8) ? 2 : 4) : 0;
        peek(3'd4, d);
        chk("R6 pin mask", d, expv);
      end
    end

    // R6 group disabled
    wr(3'd2, 8'hFF); wr(3'd3, 8'h0F);
    wr(3'd0, 8'h21); wr(3'd4, 8'h07);
    @(negedge clk); pins[3] = ~pins[3]; pins[9] = ~pins[9];
    idle(3);
    peek(3'd4, d); chk("R6 group off", d, 4);
    wr(3'd0, 8'h31);

    // R8 gating by gie
    chk("R8 g1 on", g1_irq, 1);
    gie = 1'b0; #1;
    chk("R8 gie off", g1_irq, 0);
    gie = 1'b1; #1;
    wr(3'd0, 8'h11); #1;
    chk("R8 enable off", g1_irq, 0);
    wr(3'd0, 8'h31);

    // R9 write 0 keeps, ack clears
    wr(3'd4, 8'h00);
    peek(3'd4, d); chk("R9 write0 keeps", d, 4);
    @(negedge clk); ack = 3'b100;
    @(negedge clk); ack = 3'b000;
    peek(3'd4, d); chk("R9 ack clears", d, 0);

    // R10 event coincides with ack
    @(negedge clk); pins[0] = ~pins[0];
    @(negedge clk); @(negedge clk); ack = 3'b010;
    @(negedge clk); ack = 3'b000;
    peek(3'd4, d); chk("R10 set wins", d[1], 1);
    @(negedge clk); ack = 3'b010;
    @(negedge clk); ack = 3'b000;
    peek(3'd4, d); chk("R10 later clear", d[1], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule